// File: doc/BRIEF.md
# Track Format Field Sequencer

This block times the header portion of a track format pass. A format-start command selects one of four drive units and raises the format and write-gate flags. Until the first index pulse arrives, the gap fill byte stays zero. After that pulse, each sector header is built from a fixed chain of windows. First comes an optional one-cycle address-mark strobe, then a gap window, then an ID transfer window, then an ECC-append window, and finally a one-cycle end pulse. Each window length is a preset count of byte-time ticks.

In soft-sectored mode the first address mark is written at the index pulse. Each later sector starts on the same edge that ends the one before it. In hard-sectored mode no address mark is written, and each sector waits for a sector pulse. A stop request lets the running sector finish. No further sector starts after that, and the next index pulse clears the format and write-gate flags, returning the block to idle. Serialization and ECC arithmetic are done elsewhere. This block only produces the timing flags and the gap fill byte.

The start command is a valid/ready stream. `start_rdy` is high only while the block is idle. A command is taken on a clock edge where `start_vld` and `start_rdy` are both high. A source that sees `start_rdy` low must hold its command until it is taken. All other pins are plain level or pulse signals sampled on every edge.

Top module: `trk_fmt_seq`

## Requirements
- R1: A command is taken when `start_vld` and `start_rdy` are both high, and `start_rdy` is high only while idle. The codes C0h, C8h, D0h and D8h select units 0, 1, 2 and 3: bits 7:5 are 110, bits 2:0 are 000, and the unit is bits 4:3. Taking a valid code sets `fmt_active` and `wr_gate` and loads `unit`, all visible after that edge. A command offered while a format runs is not taken and changes nothing.
- R2: A taken command with any other code is consumed with no effect: `fmt_active` stays low and `start_rdy` stays high.
- R3: While waiting for the first index pulse, `idx_seen` is low and `gap_byte` is 00h whatever `alt_gap` says. That index pulse sets `idx_seen`, which holds until the next command is taken.
- R4: In soft mode a one-cycle `am_wr` strobe is issued with the start of every sector. `gap_win` then stays high for exactly the gap preset number of byte ticks.
- R5: When the gap window expires, `xfer_en` rises and the ID window lasts for the ID preset number of byte ticks. During the ID window `xfer_en` is high and `ecc_time` is low.
- R6: When the ID window expires, `ecc_time` is high for the ECC preset number of byte ticks, and `xfer_en` stays high throughout.
- R7: When the ECC window expires, `end_time` pulses for one cycle. `xfer_en` and `ecc_time` both drop on that same edge.
- R8: In soft mode without a stop request, the next sector's `am_wr` and `gap_win` rise on the same edge as `end_time`.
- R9: In hard mode `am_wr` never rises. After the first index pulse, a sector starts only on a `sector_p` that arrives while the block waits between sectors. A sector pulse during a running sector has no effect.
- R10: A `fin_req` pulse during a format lets the running sector complete and then stops: no further `end_time` or `am_wr`, even on sector pulses. Index pulses are ignored until then. The first index pulse after the stop clears `fmt_active` and `wr_gate` and raises `start_rdy`.
- R11: `gap_byte` is 4Eh while `alt_gap`, `idx_seen` and `fmt_active` are all high, and 00h otherwise.
- R12: Window presets are written through `cfg_we`/`cfg_sel`/`cfg_val`, with select 0 for the gap, 1 for the ID and 2 for the ECC window. Select 3 is ignored. After reset the presets are 11, 6 and 4. Writes are ignored unless the block is idle, and a preset of 0 times one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Preset write strobe |
| cfg_sel | input | 2 | Preset select: 0 gap, 1 ID, 2 ECC |
| cfg_val | input | CNT_W | Preset value in byte ticks |
| start_vld | input | 1 | Format-start command valid |
| start_rdy | output | 1 | Command ready (idle) |
| start_cmd | input | 8 | Format-start command code |
| fin_req | input | 1 | Stop after the running sector |
| index_p | input | 1 | Index pulse |
| sector_p | input | 1 | Sector pulse |
| byte_tick | input | 1 | One-cycle byte-time tick |
| hard_mode | input | 1 | 1 selects hard-sectored timing |
| alt_gap | input | 1 | 1 selects the 4Eh gap fill |
| fmt_active | output | 1 | Format in progress |
| wr_gate | output | 1 | Drive write gate |
| unit | output | 2 | Selected unit |
| idx_seen | output | 1 | Index detected status |
| am_wr | output | 1 | Address-mark write strobe |
| gap_win | output | 1 | Pre-ID gap window |
| xfer_en | output | 1 | Transfer enable (ID and ECC) |
| ecc_time | output | 1 | ECC-append window |
| end_time | output | 1 | End-of-field pulse |
| gap_byte | output | 8 | Gap fill byte |

## Verification
The bench keeps the default `CNT_W` of 8 and the reset presets of 11, 6 and 4 for its first run. It then reprograms the presets to values as small as 0 and 1, which brings the one-tick window and back-to-back expiry edges within reach. Byte ticks arrive every cycle, every second cycle or every third cycle, so window lengths are counted in ticks rather than cycles. This shows that each timer counts ticks and not clocks.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WIDX, ST_WSEC, ST_GAP, ST_IDF, ST_ECC, ST_WFIN
  } tfs_state_e;

  localparam int NUM_WIN = 3;
  localparam int WIN_GAP = 0;
  localparam int WIN_ID  = 1;
  localparam int WIN_ECC = 2;

  localparam logic [7:0] FILL_ZERO = 8'h00;
  localparam logic [7:0] FILL_ALT  = 8'h4E;
endpackage

// File: rtl/tfs_cmd_decode.sv
module tfs_cmd_decode (
  input  logic [7:0] code,
  output logic       ok,
  output logic [1:0] unit_sel
);
  // unit codes C0/C8/D0/D8: 110u_u000
  always_comb begin
    ok       = (code[7:5] == 3'b110) && (code[2:0] == 3'b000);
    unit_sel = code[4:3];
  end
endmodule

// File: rtl/tfs_byte_timer.sv
module tfs_byte_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] preset,
  input  logic             tick,
  output logic             busy,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = busy && tick && (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= (preset == '0) ? CNT_W'(1) : preset;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (cnt <= CNT_W'(1)) begin
        cnt  <= '0;
        busy <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // a running window always has ticks left to count
  p_cnt_live_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0));
endmodule

// File: rtl/tfs_ctrl.sv
module tfs_ctrl
  import tfs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_take,
  input  logic [1:0]         cmd_unit,
  input  logic               index_p,
  input  logic               sector_p,
  input  logic               hard_mode,
  input  logic               alt_gap,
  input  logic               fin_req,
  input  logic [NUM_WIN-1:0] win_exp,
  output logic [NUM_WIN-1:0] win_start,
  output logic               idle,
  output logic               fmt_active,
  output logic               wr_gate,
  output logic [1:0]         unit,
  output logic               idx_seen,
  output logic               am_wr,
  output logic               gap_win,
  output logic               xfer_en,
  output logic               ecc_time,
  output logic               end_time,
  output logic [7:0]         gap_byte
);
  tfs_state_e st, nxt;
  logic fin_pend, am_set, end_set, go_idle;

  assign idle     = (st == ST_IDLE);
  assign gap_byte = (alt_gap && idx_seen && fmt_active) ? FILL_ALT : FILL_ZERO;

  always_comb begin
    nxt       = st;
    win_start = '0;
    am_set    = 1'b0;
    end_set   = 1'b0;
    go_idle   = 1'b0;
    case (st)
      ST_IDLE: if (cmd_take) nxt = ST_WIDX;
      ST_WIDX: if (index_p) begin
        if (hard_mode) nxt = ST_WSEC;
        else begin
          nxt = ST_GAP;
          win_start[WIN_GAP] = 1'b1;
          am_set = 1'b1;
        end
      end
      ST_WSEC: begin
        if (fin_pend) nxt = ST_WFIN;
        else if (sector_p) begin
          nxt = ST_GAP;
          win_start[WIN_GAP] = 1'b1;
        end
      end
      ST_GAP: if (win_exp[WIN_GAP]) begin
        nxt = ST_IDF;
        win_start[WIN_ID] = 1'b1;
      end
      ST_IDF: if (win_exp[WIN_ID]) begin
        nxt = ST_ECC;
        win_start[WIN_ECC] = 1'b1;
      end
      ST_ECC: if (win_exp[WIN_ECC]) begin
        end_set = 1'b1;
        if (fin_pend) nxt = ST_WFIN;
        else if (hard_mode) nxt = ST_WSEC;
        else begin
          nxt = ST_GAP;
          win_start[WIN_GAP] = 1'b1;
          am_set = 1'b1;
        end
      end
      ST_WFIN: if (index_p) begin
        nxt = ST_IDLE;
        go_idle = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      fmt_active <= 1'b0;
      wr_gate    <= 1'b0;
      unit       <= '0;
      idx_seen   <= 1'b0;
      fin_pend   <= 1'b0;
      am_wr      <= 1'b0;
      gap_win    <= 1'b0;
      xfer_en    <= 1'b0;
      ecc_time   <= 1'b0;
      end_time   <= 1'b0;
    end else begin
      st       <= nxt;
      am_wr    <= am_set;
      end_time <= end_set;
      gap_win  <= (nxt == ST_GAP);
      xfer_en  <= (nxt == ST_IDF) || (nxt == ST_ECC);
      ecc_time <= (nxt == ST_ECC);
      if (cmd_take) begin
        fmt_active <= 1'b1;
        wr_gate    <= 1'b1;
        unit       <= cmd_unit;
        idx_seen   <= 1'b0;
        fin_pend   <= 1'b0;
      end else begin
        if (go_idle) begin
          fmt_active <= 1'b0;
          wr_gate    <= 1'b0;
          fin_pend   <= 1'b0;
        end else if (fin_req && fmt_active) begin
          fin_pend <= 1'b1;
        end
        if (st == ST_WIDX && index_p) idx_seen <= 1'b1;
      end
    end
  end

  p_ecc_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_time |-> xfer_en);
  p_end_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    end_time |-> (!xfer_en && !ecc_time));
  p_xfer_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_en) |-> end_time);
  p_am_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    am_wr |-> (gap_win && $onehot0({am_wr, ecc_time, xfer_en})));
  p_hard_no_am_r9: assert property (@(posedge clk) disable iff (!rst_n)
    am_wr |-> !$past(hard_mode));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_active |-> (!wr_gate && !xfer_en && !am_wr && !gap_win));
endmodule

// File: rtl/trk_fmt_seq.sv
module trk_fmt_seq
  import tfs_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int GAP_DEF = 11,
  parameter int ID_DEF  = 6,
  parameter int ECC_DEF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_val,
  input  logic             start_vld,
  output logic             start_rdy,
  input  logic [7:0]       start_cmd,
  input  logic             fin_req,
  input  logic             index_p,
  input  logic             sector_p,
  input  logic             byte_tick,
  input  logic             hard_mode,
  input  logic             alt_gap,
  output logic             fmt_active,
  output logic             wr_gate,
  output logic [1:0]       unit,
  output logic             idx_seen,
  output logic             am_wr,
  output logic             gap_win,
  output logic             xfer_en,
  output logic             ecc_time,
  output logic             end_time,
  output logic [7:0]       gap_byte
);
  logic             code_ok, cmd_take;
  logic [1:0]       code_unit;
  logic [NUM_WIN-1:0] t_start, t_exp, t_busy;
  logic [CNT_W-1:0] preset [NUM_WIN];

  tfs_cmd_decode u_dec (
    .code(start_cmd), .ok(code_ok), .unit_sel(code_unit)
  );

  assign cmd_take = start_vld && start_rdy && code_ok;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam int DEF = (k == WIN_GAP) ? GAP_DEF :
                         (k == WIN_ID)  ? ID_DEF  : ECC_DEF;
    always_ff @(posedge clk) begin
      if (!rst_n)
        preset[k] <= CNT_W'(DEF);
      else if (cfg_we && start_rdy && (cfg_sel == 2'(k)))
        preset[k] <= cfg_val;
    end

    tfs_byte_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(t_start[k]), .preset(preset[k]),
      .tick(byte_tick), .busy(t_busy[k]), .expire(t_exp[k])
    );
  end

  tfs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_take(cmd_take), .cmd_unit(code_unit),
    .index_p(index_p), .sector_p(sector_p), .hard_mode(hard_mode),
    .alt_gap(alt_gap), .fin_req(fin_req), .win_exp(t_exp),
    .win_start(t_start), .idle(start_rdy), .fmt_active(fmt_active),
    .wr_gate(wr_gate), .unit(unit), .idx_seen(idx_seen), .am_wr(am_wr),
    .gap_win(gap_win), .xfer_en(xfer_en), .ecc_time(ecc_time),
    .end_time(end_time), .gap_byte(gap_byte)
  );

  p_one_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(t_busy));
  p_zero_fill_pre_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_seen |-> (gap_byte == 8'h00));
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_rdy |-> !fmt_active);
endmodule

// File: tb/trk_fmt_seq_tb_top.sv
module trk_fmt_seq_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [CNT_W-1:0] cfg_val = 0;
  logic start_vld = 0, start_rdy; logic [7:0] start_cmd = 0;
  logic fin_req = 0, index_p = 0, sector_p = 0, byte_tick = 0;
  logic hard_mode = 0, alt_gap = 0;
  logic fmt_active, wr_gate, idx_seen, am_wr, gap_win, xfer_en, ecc_time, end_time;
  logic [1:0] unit; logic [7:0] gap_byte;

  trk_fmt_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_val(cfg_val), .start_vld(start_vld), .start_rdy(start_rdy),
    .start_cmd(start_cmd), .fin_req(fin_req), .index_p(index_p),
    .sector_p(sector_p), .byte_tick(byte_tick), .hard_mode(hard_mode),
    .alt_gap(alt_gap), .fmt_active(fmt_active), .wr_gate(wr_gate),
    .unit(unit), .idx_seen(idx_seen), .am_wr(am_wr), .gap_win(gap_win),
    .xfer_en(xfer_en), .ecc_time(ecc_time), .end_time(end_time),
    .gap_byte(gap_byte)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int tick_div = 1, tick_ph = 0;
  int n_gt, n_it, n_et, n_am, n_end, n_b2b, bad_gap, n_alt, n_endbad;

  typedef struct packed {
    logic wcfg; logic hard; logic alt; logic [1:0] tdiv;
    logic [7:0] gap; logic [7:0] idl; logic [7:0] ecc;
    logic [7:0] cmd; logic [1:0] unit;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 1'b0, 1'b0, 2'd1, 8'd11, 8'd6, 8'd4, 8'hC0, 2'd0},
    '{1'b1, 1'b0, 1'b1, 2'd2, 8'd3,  8'd2, 8'd1, 8'hC8, 2'd1},
    '{1'b1, 1'b1, 1'b0, 2'd1, 8'd5,  8'd4, 8'd2, 8'hD0, 2'd2},
    '{1'b1, 1'b1, 1'b1, 2'd3, 8'd2,  8'd1, 8'd1, 8'hD8, 2'd3},
    '{1'b1, 1'b0, 1'b0, 2'd3, 8'd1,  8'd1, 8'd1, 8'hD0, 2'd2}
  };

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    n_gt = 0; n_it = 0; n_et = 0; n_am = 0; n_end = 0;
    n_b2b = 0; bad_gap = 0; n_alt = 0; n_endbad = 0;
  endtask

  // one clock: new tick for the coming edge, then tally the current cycle
  task automatic step();
    @(negedge clk);
    tick_ph = (tick_ph + 1) % tick_div;
    byte_tick = (tick_ph == 0);
    if (gap_win && byte_tick) n_gt++;
    if (xfer_en && !ecc_time && byte_tick) n_it++;
    if (ecc_time && byte_tick) n_et++;
    if (am_wr) n_am++;
    if (end_time) n_end++;
    if (end_time && gap_win) n_b2b++;
    if (end_time && (xfer_en || ecc_time)) n_endbad++;
    if (fmt_active && idx_seen) begin
      if (gap_byte != (alt_gap ? 8'h4E : 8'h00)) bad_gap++;
      if (gap_byte == 8'h4E) n_alt++;
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_end(input int target, input string req);
    for (int i = 0; i < 4000 && n_end < target; i++) step();
    chk_eq(req, "end pulses reached", n_end, target);
  endtask

  task automatic cfg_wr(input logic [1:0] s, input int v);
    cfg_we = 1; cfg_sel = s; cfg_val = CNT_W'(v); step(); cfg_we = 0;
  endtask

  task automatic pulse_idx();  index_p = 1;  step(); index_p = 0;  endtask
  task automatic pulse_sec();  sector_p = 1; step(); sector_p = 0; endtask
  task automatic pulse_fin();  fin_req = 1;  step(); fin_req = 0;  endtask

  task automatic send_cmd(input logic [7:0] c);
    start_vld = 1; start_cmd = c; step(); start_vld = 0;
  endtask

  task automatic run_vec(input vec_t v);
    tick_div = int'(v.tdiv); tick_ph = 0;
    hard_mode = v.hard; alt_gap = v.alt;
    if (v.wcfg) begin
      cfg_wr(2'd0, int'(v.gap)); cfg_wr(2'd1, int'(v.idl)); cfg_wr(2'd2, int'(v.ecc));
    end
    clr();
    send_cmd(v.cmd);
    chk_eq("R1", "fmt_active after start", int'(fmt_active), 1);
    chk_eq("R1", "wr_gate after start", int'(wr_gate), 1);
    chk_eq("R1", "unit", int'(unit), int'(v.unit));
    chk_eq("R1", "start_rdy busy", int'(start_rdy), 0);
    steps(3);
    chk_eq("R3", "gap_byte before index", int'(gap_byte), 0);
    chk_eq("R3", "idx_seen before index", int'(idx_seen), 0);
    pulse_idx();
    chk_eq("R3", "idx_seen after index", int'(idx_seen), 1);
    if (v.hard) begin
      steps(3);
      chk_eq("R9", "hard waits for sector pulse", int'(gap_win), 0);
      pulse_sec(); steps(2); pulse_sec();  // second pulse lands inside the sector
      wait_end(1, "R9");
      steps(2); pulse_sec(); pulse_fin();
      wait_end(2, "R10");
    end else begin
      wait_end(1, "R8");
      pulse_fin();
      wait_end(2, "R10");
    end
    steps(10);
    pulse_sec(); steps(5);
    chk_eq("R10", "no sector after stop", n_end, 2);
    chk_eq("R10", "still formatting until index", int'(fmt_active), 1);
    chk_eq(v.hard ? "R9" : "R4", "am strobes", n_am, v.hard ? 0 : 2);
    chk_eq("R4", "gap ticks", n_gt, 2 * int'(v.gap));
    chk_eq("R5", "id ticks", n_it, 2 * int'(v.idl));
    chk_eq("R6", "ecc ticks", n_et, 2 * int'(v.ecc));
    chk_eq("R7", "end with xfer/ecc high", n_endbad, 0);
    chk_eq("R8", "back-to-back starts", n_b2b, v.hard ? 0 : 1);
    pulse_idx();
    chk_eq("R10", "fmt_active cleared", int'(fmt_active), 0);
    chk_eq("R10", "wr_gate cleared", int'(wr_gate), 0);
    chk_eq("R10", "ready again", int'(start_rdy), 1);
    chk_eq("R11", "gap byte mismatches", bad_gap, 0);
    chk_eq("R11", "alt fill seen", int'(n_alt > 0), int'(v.alt));
    chk_eq("R11", "gap_byte after format", int'(gap_byte), 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clr();
    steps(3);
    rst_n = 1;
    step();
    // reset state
    chk_eq("R1", "reset start_rdy", int'(start_rdy), 1);
    chk_eq("R1", "reset fmt_active", int'(fmt_active), 0);
    chk_eq("R10", "reset wr_gate", int'(wr_gate), 0);
    chk_eq("R3", "reset idx_seen", int'(idx_seen), 0);
    chk_eq("R7", "reset outputs", int'({am_wr, gap_win, xfer_en, ecc_time, end_time}), 0);
    chk_eq("R11", "reset gap_byte", int'(gap_byte), 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R2: malformed codes are consumed without effect
    tick_div = 1; hard_mode = 0; alt_gap = 0;
    send_cmd(8'hC4);
    chk_eq("R2", "C4h ignored", int'(fmt_active), 0);
    chk_eq("R2", "ready after C4h", int'(start_rdy), 1);
    send_cmd(8'hE0);
    chk_eq("R2", "E0h ignored", int'(fmt_active), 0);

    // R12 config frozen during format; R1 command refused while busy; R10 early index ignored
    cfg_wr(2'd0, 4); cfg_wr(2'd1, 2); cfg_wr(2'd2, 1); cfg_wr(2'd3, 7);
    clr();
    send_cmd(8'hC0);
    pulse_idx();
    steps(2);
    cfg_wr(2'd0, 9);
    send_cmd(8'hD8);
    chk_eq("R1", "unit unchanged while busy", int'(unit), 0);
    wait_end(1, "R12");
    pulse_fin();
    pulse_idx();
    wait_end(2, "R10");
    steps(4);
    chk_eq("R10", "index during sector ignored", int'(fmt_active), 1);
    chk_eq("R12", "gap ticks with frozen preset", n_gt, 8);
    chk_eq("R12", "id ticks", n_it, 4);
    chk_eq("R12", "ecc ticks (sel 3 ignored)", n_et, 2);
    pulse_idx();
    chk_eq("R10", "cleared after stop", int'(fmt_active), 0);

    // R12 zero preset times one tick; stop in the first sector
    cfg_wr(2'd0, 0); cfg_wr(2'd1, 0); cfg_wr(2'd2, 1);
    tick_div = 2; tick_ph = 0;
    clr();
    send_cmd(8'hC8);
    pulse_idx();
    pulse_fin();
    wait_end(1, "R12");
    steps(6);
    chk_eq("R12", "zero gap = one tick", n_gt, 1);
    chk_eq("R12", "zero id = one tick", n_it, 1);
    chk_eq("R10", "single sector", n_end, 1);
    chk_eq("R4", "single am strobe", n_am, 1);
    pulse_idx();
    chk_eq("R10", "idle at end", int'(start_rdy), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule